// File: doc/BRIEF.md
# L1 Invalidation Walk Controller

This block handles cache-invalidate requests from a compute unit aimed at a small L1 data cache. Only one invalidation may be in flight. An accepted request starts a walk over every line index, from 0 up to the last block. For each index the block reads the stored line address through a lookup port. It then issues one evict request with a zero length on a valid/ready downstream port.

Each evict that is issued raises a count of outstanding evictions, and each acknowledgement lowers it. Acknowledgements may arrive while the walk is still issuing. The requester gets a single completion pulse once the walk has ended and the count has drained to zero. The block then frees itself for the next request.

A request that arrives while an invalidation is pending gets a retry answer and is otherwise ignored. An acknowledgement that arrives when nothing is outstanding is flagged as an error and leaves the count unchanged.

Top module: `inv_walk_ctrl`

## Requirements
- R1: When no invalidation is pending, `inv_req_i` is answered in the same cycle with `inv_accept_o`=1 and `inv_retry_o`=0. In the next cycle `evict_valid_o` is 1 and `line_idx_o` is 0.
- R2: An invalidation is pending from the cycle after acceptance through the cycle in which `done_o` is high. During that time `inv_req_i` is answered with `inv_retry_o`=1 and `inv_accept_o`=0, and the walk in progress neither restarts nor gains extra evicts.
- R3: One accepted invalidation produces exactly NUM_BLOCKS evict handshakes, for indices 0, 1, … NUM_BLOCKS-1 in ascending order. `line_idx_o` shows the index being issued, and `evict_addr_o` equals the `line_addr_i` returned for it.
- R4: Whenever `evict_valid_o` is 1, `evict_len_o` is 0.
- R5: The index advances only on a cycle where `evict_valid_o` and `evict_ready_i` are both 1. While ready is low, valid stays high and the index and address hold.
- R6: `done_o` is a one-cycle pulse. It is high exactly in the first cycle in which all NUM_BLOCKS evicts have been handshaken and every one of them has been acknowledged. Acknowledgements taken during the walk count toward this.
- R7: `ack_err_o` is high in the same cycle as `ack_i` when no invalidation is pending or the outstanding count is zero. Such an acknowledgement does not change the count, so completion timing is unaffected.
- R8: A request presented in the cycle after `done_o` is accepted.
- R9: After reset, `evict_valid_o`, `done_o`, `ack_err_o`, `inv_accept_o` and `inv_retry_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inv_req_i | input | 1 | Invalidate request from the compute unit |
| inv_accept_o | output | 1 | Request taken this cycle |
| inv_retry_o | output | 1 | Request refused, present again later |
| done_o | output | 1 | Completion pulse for the accepted invalidation |
| line_idx_o | output | IDX_W | Line index being looked up |
| line_addr_i | input | ADDR_W | Line address stored at `line_idx_o` |
| evict_valid_o | output | 1 | Evict request valid |
| evict_ready_i | input | 1 | Downstream accepts the evict |
| evict_addr_o | output | ADDR_W | Line address to evict |
| evict_len_o | output | LEN_W | Access length of the evict, always 0 |
| ack_i | input | 1 | Eviction acknowledgement |
| ack_err_o | output | 1 | Acknowledgement arrived with nothing outstanding |

## Verification
The bench builds the block with NUM_BLOCKS=8, which keeps each walk short enough to run several of them. Each walk uses a different mix of downstream stalls and acknowledgement timing: all acknowledgements after the walk, one every cycle during it, and one every other cycle. The small count also makes it easy to reach the drain phase, a refused request in the completion cycle followed by acceptance in the next, and stray acknowledgements both when idle and before the first evict.

// File: rtl/inv_walk_pkg.sv
package inv_walk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_DRAIN = 2'd2
  } inv_state_e;
endpackage

// File: rtl/inv_walk_seq.sv
module inv_walk_seq #(
  parameter int NUM_BLOCKS = 16,
  parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             fire_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  idx_q <= '0;
    else if (start_i)             idx_q <= '0;
    else if (active_i && fire_i)  idx_q <= last_o ? '0 : idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

  a_r3_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (int'(idx_q) < NUM_BLOCKS));

  a_r5_idx_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !fire_i && !start_i) |=> (idx_q == $past(idx_q)));
endmodule

// File: rtl/inv_pend_cnt.sv
module inv_pend_cnt #(
  parameter int MAX_CNT = 16,
  parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             inc_i,
  input  logic             ack_i,
  output logic             zero_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign zero_o = (cnt_q == '0);
  assign err_o  = ack_i && (!active_i || zero_o);
  assign dec    = ack_i && !err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(inc_i) - CNT_W'(dec);
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= MAX_CNT);

  a_r7_err_no_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (cnt_q == $past(cnt_q) + CNT_W'($past(inc_i))));
endmodule

// File: rtl/inv_walk_ctrl.sv
module inv_walk_ctrl
  import inv_walk_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_req_i,
  output logic              inv_accept_o,
  output logic              inv_retry_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  line_idx_o,
  input  logic [ADDR_W-1:0] line_addr_i,
  output logic              evict_valid_o,
  input  logic              evict_ready_i,
  output logic [ADDR_W-1:0] evict_addr_o,
  output logic [LEN_W-1:0]  evict_len_o,
  input  logic              ack_i,
  output logic              ack_err_o
);
  inv_state_e state_q, state_d;
  logic       fire, last, cnt_zero, pending;

  assign pending       = (state_q != ST_IDLE);
  assign inv_accept_o  = inv_req_i && !pending;
  assign inv_retry_o   = inv_req_i && pending;
  assign evict_valid_o = (state_q == ST_WALK);
  assign fire          = evict_valid_o && evict_ready_i;
  assign evict_addr_o  = line_addr_i;
  assign evict_len_o   = '0;
  // walk done and nothing outstanding
  assign done_o        = (state_q == ST_DRAIN) && cnt_zero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (inv_accept_o)  state_d = ST_WALK;
      ST_WALK:  if (fire && last)  state_d = ST_DRAIN;
      ST_DRAIN: if (cnt_zero)      state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  inv_walk_seq #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (inv_accept_o),
    .active_i (evict_valid_o),
    .fire_i   (fire),
    .idx_o    (line_idx_o),
    .last_o   (last)
  );

  inv_pend_cnt #(.MAX_CNT(NUM_BLOCKS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (pending),
    .inc_i    (fire),
    .ack_i    (ack_i),
    .zero_o   (cnt_zero),
    .err_o    (ack_err_o)
  );

  a_r1_walk_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_accept_o |=> (evict_valid_o && line_idx_o == '0));

  a_r5_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_o && !evict_ready_i) |=> (evict_valid_o && $stable(line_idx_o)));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_retry_o && evict_valid_o && !evict_ready_i) |=> (line_idx_o == $past(line_idx_o)));
endmodule

// File: tb/inv_walk_ctrl_tb_top.sv
module inv_walk_ctrl_tb_top;
  localparam int N      = 8;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int IDX_W  = $clog2(N);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inv_req = 1'b0;
  logic              inv_accept, inv_retry, done;
  logic [IDX_W-1:0]  line_idx;
  logic [ADDR_W-1:0] line_addr;
  logic              evict_valid, evict_ready = 1'b0;
  logic [ADDR_W-1:0] evict_addr;
  logic [LEN_W-1:0]  evict_len;
  logic              ack = 1'b0;
  logic              ack_err;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [ADDR_W-1:0] line_of(int i);
    return 32'h0004_0000 + i * 32'h140 ^ (i << 20);
  endfunction
  assign line_addr = line_of(int'(line_idx));

  inv_walk_ctrl #(.NUM_BLOCKS(N), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .inv_req_i(inv_req), .inv_accept_o(inv_accept),
    .inv_retry_o(inv_retry), .done_o(done), .line_idx_o(line_idx), .line_addr_i(line_addr),
    .evict_valid_o(evict_valid), .evict_ready_i(evict_ready), .evict_addr_o(evict_addr),
    .evict_len_o(evict_len), .ack_i(ack), .ack_err_o(ack_err));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard and model state
  logic [ADDR_W-1:0] exp_q[$];
  int  ready_mode = 0, ack_mode = 2, cyc = 0;
  bit  ack_force = 0, mon_on = 0;
  bit  busy_m = 0, hs_p = 0, ack_p = 0, acc_p = 0, done_p = 0, stall_p = 0;
  int  cnt_m = 0, issued = 0;
  logic [IDX_W-1:0]  idx_p;
  logic [ADDR_W-1:0] addr_p;

  // ready driver
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: evict_ready <= 1'b1;
      1: evict_ready <= (cyc % 3) != 0;
      default: evict_ready <= 1'b0;
    endcase
  end

  // monitor: settled values a quarter period before the rising edge
  always @(negedge clk) begin
    #5;
    if (mon_on) begin
      cnt_m += int'(hs_p) - int'(ack_p);
      issued += int'(hs_p);
      if (acc_p) begin busy_m = 1; issued = 0; end
      if (done_p) busy_m = 0;
      if (busy_m || done)
        chk(done == (busy_m && issued == N && cnt_m == 0), "R6", "done", done,
            busy_m && issued == N && cnt_m == 0);
      if (done) begin
        chk(exp_q.size() == 0, "R3", "evicts left", exp_q.size(), 0);
        chk(issued == N, "R3", "evict count", issued, N);
      end
      if (stall_p)
        chk(evict_valid && line_idx == idx_p && evict_addr == addr_p, "R5",
            "stall hold", {line_idx, evict_addr}, {idx_p, addr_p});
      begin
        bit auto_ack;
        case (ack_mode)
          0: auto_ack = 1;
          1: auto_ack = cyc[0];
          default: auto_ack = (issued == N);
        endcase
        ack = ack_force || (auto_ack && busy_m && cnt_m > 0);
      end
      #1;
      ack_p = ack && busy_m && cnt_m > 0;
      if (ack) chk(ack_err == !ack_p, "R7", "ack_err", ack_err, !ack_p);
      hs_p = evict_valid && evict_ready;
      if (hs_p) begin
        logic [ADDR_W-1:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
        chk(evict_addr === e, "R3", "evict addr", evict_addr, e);
        chk(int'(line_idx) == issued, "R3", "index order", line_idx, issued);
        chk(evict_len == 0, "R4", "evict len", evict_len, 0);
      end
      stall_p = evict_valid && !evict_ready;
      idx_p = line_idx;
      addr_p = evict_addr;
      acc_p = inv_req && inv_accept;
      if (inv_req) begin
        chk(inv_accept == !busy_m, "R1", "accept", inv_accept, !busy_m);
        chk(inv_retry == busy_m, "R2", "retry", inv_retry, busy_m);
      end
      if (acc_p) for (int i = 0; i < N; i++) exp_q.push_back(line_of(i));
      done_p = done;
    end
  end

  task automatic request();
    @(negedge clk) inv_req = 1'b1;
    @(negedge clk) inv_req = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!evict_valid && !done && !ack_err && !inv_accept && !inv_retry, "R9", "reset outputs",
        {evict_valid, done, ack_err, inv_accept, inv_retry}, 0);
    rst_n = 1'b1;
    mon_on = 1;
    // R7 stray ack while idle
    @(negedge clk) ack_force = 1;
    @(negedge clk) ack_force = 0;
    // walk 1: free flow, acks after the walk, retry mid-walk (R2)
    ready_mode = 0; ack_mode = 2;
    request();
    repeat (2) @(negedge clk);
    request();
    wait_done();
    // R2 request during the done cycle is refused, R8 next cycle accepted
    inv_req = 1'b1;
    @(negedge clk);
    @(negedge clk) inv_req = 1'b0;
    // walk 2 (started above): stalls, acks every cycle during the walk
    ready_mode = 1; ack_mode = 0;
    wait_done();
    // walk 3: hold ready low, stray ack at count zero (R7), then drain
    repeat (2) @(negedge clk);
    ready_mode = 2; ack_mode = 1;
    request();
    @(negedge clk) ack_force = 1;
    @(negedge clk) ack_force = 0;
    repeat (2) @(negedge clk);
    ready_mode = 1;
    wait_done();
    repeat (3) @(negedge clk);
    chk(!evict_valid && !done, "R9", "idle after walks", {evict_valid, done}, 0);
    summary();
  end
endmodule